// File: doc/BRIEF.md
# Video Clamp Pulse Generator

This block makes the clamp-enable window that a digitizing video front end needs once per line. In its timed mode it watches a horizontal sync that is synchronous to the pixel clock and already normalized to active high. On the end of each sync pulse it waits a programmed number of pixel clocks, then holds the clamp output active for a programmed number of pixel clocks.

In its bypass mode the window comes from an external clamp input instead. That input is first brought into the pixel-clock domain through a two-flop synchronizer, and then its polarity is normalized according to a configuration bit.

The configuration fields are static levels, driven by a register bank outside this block. That bank is expected to reset them to the defaults held in the package. No data stream passes through the block, so every pin is a plain level and there is no valid/ready handshake or back-pressure.

Top module: `clamp_pulse_gen`

## Requirements
- R1: A trailing edge is the first rising clock edge at which `hsync_i` is sampled low after having been sampled high. Only this edge starts a window. A rising `hsync_i`, or an `hsync_i` held high, never starts one.
- R2: With `src_sel_i` = 0 and placement P, `clamp_o` goes high P+1 clock cycles after the trailing-edge clock edge. So P = 0 gives one cycle of delay, and P = 255 gives 256.
- R3: Once high, the timed clamp stays high for exactly D consecutive cycles, where D is `dur_i`, and then returns low.
- R4: When `dur_i` = 0, a trailing edge produces no clamp pulse at all.
- R5: A trailing edge that arrives during a delay or during an active window restarts the sequence. `clamp_o` is low on the next cycle, and the new window is timed from the new edge only.
- R6: `src_sel_i` = 0 selects the timed window and `src_sel_i` = 1 selects the external path. The unselected source has no effect on `clamp_o`.
- R7: The external path passes `clamp_ext_i` through two flops. `ext_pol_i` = 0 treats it as active high and `ext_pol_i` = 1 treats it as active low. A change on the input appears on `clamp_o` two cycles later.
- R8: The package defaults are placement 8, duration 20 and external polarity 1 (active low). With these defaults the timed window spans cycles 9 to 28 after the trailing edge.
- R9: While `rst_n` is low and right after reset, with `src_sel_i` = 0, `clamp_o` is low and the timer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_i | input | 1 | Horizontal sync, active high, synchronous to clk |
| clamp_ext_i | input | 1 | External clamp request, asynchronous |
| place_i | input | CNT_W | Delay from the sync trailing edge, in clocks |
| dur_i | input | CNT_W | Window length in clocks |
| src_sel_i | input | 1 | 0: timed from sync, 1: external input |
| ext_pol_i | input | 1 | 0: external active high, 1: active low |
| clamp_o | output | 1 | Clamp active |

## Verification
The assertions check the following on every cycle:
- no window runs longer than the programmed duration;
- a window only rises out of the delay phase;
- every trailing edge forces the output low on the next cycle, and a zero duration sends the timer back to idle;
- the external path tracks the input delayed by two cycles, under the current polarity.

Some behaviour only the directed scenarios can show:
- the exact rise and fall cycles for chosen placements, including 0, 255 and the defaults;
- that a restarted window is timed from the new edge;
- that a rising sync or the unselected source leaves the output untouched.

// File: rtl/clamp_pkg.sv
package clamp_pkg;
  localparam int unsigned CLP_CNT_W = 8;

  typedef enum logic [1:0] {
    TMR_IDLE   = 2'd0,
    TMR_DELAY  = 2'd1,
    TMR_ACTIVE = 2'd2
  } tmr_state_e;

  // Reset values the surrounding register bank should give the fields
  localparam logic [CLP_CNT_W-1:0] CLP_DEF_PLACE   = 8'd8;
  localparam logic [CLP_CNT_W-1:0] CLP_DEF_DUR     = 8'd20;
  localparam logic                 CLP_DEF_EXT_POL = 1'b1;
endpackage

// File: rtl/clamp_sync.sv
module clamp_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= RST_VAL;
          else        chain_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= RST_VAL;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/clamp_trail_det.sv
module clamp_trail_det (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic trail_o
);
  logic level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level_i;
  end

  // High during the cycle whose closing edge first samples the level low
  assign trail_o = level_q & ~level_i;
endmodule

// File: rtl/clamp_window_timer.sv
module clamp_window_timer
  import clamp_pkg::*;
#(
  parameter int unsigned CNT_W = CLP_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] place_i,
  input  logic [CNT_W-1:0] dur_i,
  output logic             active_o
);
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;
  localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  tmr_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TMR_IDLE;
      cnt_q   <= CNT_ZERO;
    end else if (start_i) begin
      if (dur_i == CNT_ZERO) begin
        state_q <= TMR_IDLE;
        cnt_q   <= CNT_ZERO;
      end else begin
        state_q <= TMR_DELAY;
        cnt_q   <= place_i;
      end
    end else begin
      case (state_q)
        TMR_DELAY: begin
          if (cnt_q == CNT_ZERO) begin
            state_q <= TMR_ACTIVE;
            cnt_q   <= dur_i - CNT_ONE;
          end else begin
            cnt_q <= cnt_q - CNT_ONE;
          end
        end
        TMR_ACTIVE: begin
          if (cnt_q == CNT_ZERO) state_q <= TMR_IDLE;
          else                   cnt_q   <= cnt_q - CNT_ONE;
        end
        default: begin
          state_q <= TMR_IDLE;
          cnt_q   <= CNT_ZERO;
        end
      endcase
    end
  end

  assign active_o = (state_q == TMR_ACTIVE);

  // Checker: length of the current active run
  logic [CNT_W:0] run_len_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_len_q <= '0;
    else if (active_o) run_len_q <= run_len_q + 1'b1;
    else               run_len_q <= '0;
  end

  AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    active_o |-> (run_len_q < {1'b0, dur_i}));  // R3
  AST_RISE_AFTER_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_o) |-> ($past(state_q) == TMR_DELAY));  // R2
  AST_ZERO_DUR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && dur_i == CNT_ZERO) |=> (state_q == TMR_IDLE));  // R4
  AST_RESTART_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !active_o);  // R5
endmodule

// File: rtl/clamp_pulse_gen.sv
module clamp_pulse_gen
  import clamp_pkg::*;
#(
  parameter int unsigned CNT_W       = CLP_CNT_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hsync_i,
  input  logic             clamp_ext_i,
  input  logic [CNT_W-1:0] place_i,
  input  logic [CNT_W-1:0] dur_i,
  input  logic             src_sel_i,
  input  logic             ext_pol_i,
  output logic             clamp_o
);
  logic trail;
  logic timed_active;
  logic ext_sync;
  logic ext_active;

  clamp_trail_det u_trail (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (hsync_i),
    .trail_o (trail)
  );

  clamp_window_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (trail),
    .place_i  (place_i),
    .dur_i    (dur_i),
    .active_o (timed_active)
  );

  clamp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ext_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (clamp_ext_i),
    .sync_o  (ext_sync)
  );

  assign ext_active = ext_sync ^ ext_pol_i;
  assign clamp_o    = src_sel_i ? ext_active : timed_active;

  // Checker: cycles since reset, saturating
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             age_q <= 2'd0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  AST_EXT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3 && src_sel_i) |-> (clamp_o == ($past(clamp_ext_i, 2) ^ ext_pol_i)));  // R7
endmodule

// File: tb/clamp_pulse_gen_bench.sv
module clamp_pulse_gen_bench;
  import clamp_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hsync = 1'b0;
  logic       ext = 1'b0;
  logic [7:0] place = CLP_DEF_PLACE;
  logic [7:0] dur = CLP_DEF_DUR;
  logic       src = 1'b0;
  logic       pol = CLP_DEF_EXT_POL;
  logic       clamp;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  clamp_pulse_gen u_clamp_pulse_gen (
    .clk(clk), .rst_n(rst_n), .hsync_i(hsync), .clamp_ext_i(ext),
    .place_i(place), .dur_i(dur), .src_sel_i(src), .ext_pol_i(pol),
    .clamp_o(clamp)
  );

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: clamp actual %b expected %b", req, $time, act, exp);
    end
  endtask

  // Drives a one-cycle high then low; the next posedge is the trailing edge
  task automatic trig();
    @(negedge clk) hsync = 1'b1;
    @(negedge clk) hsync = 1'b0;
  endtask

  // Samples after trailing edge + k, for k = 0..len
  task automatic check_window(string req, int p, int d, int len);
    for (int k = 0; k <= len; k++) begin
      @(negedge clk);
      chk(req, clamp, (d != 0) && (k >= p + 1) && (k <= p + d));
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 in reset", clamp, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 after reset", clamp, 1'b0);
  endtask

  task automatic t_defaults();
    src = 0; place = CLP_DEF_PLACE; dur = CLP_DEF_DUR;
    trig();
    check_window("R8 default window", 8, 20, 40);
  endtask

  task automatic t_place_zero();
    place = 0; dur = 1;
    trig();
    check_window("R2 placement 0", 0, 1, 6);
    place = 3; dur = 5;
    trig();
    check_window("R3 duration 5", 3, 5, 12);
  endtask

  task automatic t_place_max();
    place = 8'd255; dur = 8'd2;
    trig();
    check_window("R2 placement 255", 255, 2, 262);
  endtask

  task automatic t_zero_dur();
    place = 2; dur = 0;
    trig();
    check_window("R4 zero duration", 2, 0, 20);
  endtask

  task automatic t_rising_only();
    place = 0; dur = 4;
    @(negedge clk) hsync = 1'b1;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      chk("R1 rising or held high", clamp, 1'b0);
    end
    @(negedge clk) hsync = 1'b0;
    check_window("R1 trailing edge", 0, 4, 8);
  endtask

  task automatic t_restart_delay();
    place = 10; dur = 5;
    trig();
    repeat (4) @(negedge clk);
    trig();
    check_window("R5 restart in delay", 10, 5, 20);
  endtask

  task automatic t_restart_pulse();
    place = 2; dur = 10;
    trig();
    repeat (6) @(negedge clk);
    chk("R5 mid pulse high", clamp, 1'b1);
    trig();
    check_window("R5 restart in pulse", 2, 10, 16);
  endtask

  task automatic t_ext_high();
    src = 1; pol = 0; ext = 0;
    repeat (4) @(negedge clk);
    chk("R7 high-pol idle", clamp, 1'b0);
    ext = 1'b1;
    @(negedge clk); chk("R7 latency 1", clamp, 1'b0);
    @(negedge clk); chk("R7 latency 2", clamp, 1'b1);
    ext = 1'b0;
    @(negedge clk); chk("R7 fall 1", clamp, 1'b1);
    @(negedge clk); chk("R7 fall 2", clamp, 1'b0);
  endtask

  task automatic t_ext_low();
    src = 1; pol = 1; ext = 1;
    repeat (4) @(negedge clk);
    chk("R7 low-pol idle", clamp, 1'b0);
    ext = 1'b0;
    repeat (2) @(negedge clk);
    chk("R7 low-pol active", clamp, 1'b1);
    ext = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7 low-pol release", clamp, 1'b0);
  endtask

  task automatic t_unselected();
    // external path selected, inactive; sync edges must not show
    src = 1; pol = 0; ext = 0; place = 0; dur = 6;
    repeat (3) @(negedge clk);
    trig();
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      chk("R6 sync ignored in ext mode", clamp, 1'b0);
    end
    // timed path selected and idle; external toggling must not show
    src = 0; pol = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk) ext = ~ext;
      chk("R6 ext ignored in timed mode", clamp, 1'b0);
    end
    ext = 0;
  endtask

  initial begin
    t_reset();
    t_defaults();
    t_place_zero();
    t_place_max();
    t_zero_dur();
    t_rising_only();
    t_restart_delay();
    t_restart_pulse();
    t_ext_high();
    t_ext_low();
    t_unselected();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule